// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the architectural register store of a 32-bit processor core with seven operating modes. Software sees sixteen registers numbered 0 to 15. For most numbers every mode reaches the same storage. The stack pointer (register 13) and the link register (register 14) each have a private copy in every exception mode. The fast-interrupt mode also has private copies of registers 7 to 12. Register 15 is the program counter and lives outside the block. A read of it returns the counter input. A write to it appears on a counter-load output and touches no storage.

The block also holds one saved status word for each of the five exception modes. There are two combinational read ports and one clocked write port, all addressed by a 4-bit register number in the current mode. A saved-status read/write path works on the current mode's slot. A separate exception-entry port stores the return address into the target mode's link register and the current status into that mode's saved-status slot, both at one clock edge. The surrounding pipeline supplies the mode, the counter and all write data. Decode, arithmetic and live status logic sit outside the block.

Top module: `bnk_regfile`

## Requirements
- R1: After reset every register, in every mode, reads 0 and every saved-status slot reads 0.
- R2: The mode input is decoded as 5'b10000 user, 5'b10001 fast interrupt, 5'b10010 interrupt, 5'b10011 supervisor, 5'b10111 abort, 5'b11011 undefined and 5'b11111 system. Any other value behaves exactly as user.
- R3: Registers 0 to 6 are one set shared by all modes. Registers 7 to 12 are one set shared by every mode except fast interrupt.
- R4: Fast-interrupt mode has its own registers 7 to 12, separate from the set seen by the other modes.
- R5: Registers 13 and 14 have one copy shared by user and system mode, plus a private copy for each of the five exception modes.
- R6: A read of register 15 on either port returns pc_i. A write to register 15 raises pc_load_o with pc_load_data equal to wr_data in that same cycle and changes no stored register.
- R7: A write lands at the clock edge and is visible from the next cycle. A read of the same register in the cycle of the write returns the old value.
- R8: When exc_en is high and exc_mode decodes to an exception mode, that mode's register 14 takes exc_lr and its saved-status slot takes exc_cpsr at the same edge. When exc_mode decodes to user or system, the exception port has no effect.
- R9: When the exception port and the normal write port, or the saved-status write, target the same storage at one edge, the exception value is kept. Writes to other storage in that cycle still land.
- R10: spsr_rd_data returns the current mode's saved-status slot and spsr_wr_en writes it. In user or system mode the read returns 0 and the write is ignored.
- R11: The two read ports are independent. Both return correct data for any pair of register numbers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | Current operating mode |
| rd_a_idx | input | 4 | Read port A register number |
| rd_a_data | output | DW | Read port A data |
| rd_b_idx | input | 4 | Read port B register number |
| rd_b_data | output | DW | Read port B data |
| wr_en | input | 1 | Normal write enable |
| wr_idx | input | 4 | Normal write register number |
| wr_data | input | DW | Normal write data |
| pc_i | input | DW | Program counter value returned for register 15 |
| pc_load_o | output | 1 | Write to register 15 in this cycle |
| pc_load_data | output | DW | New counter value for the load |
| spsr_wr_en | input | 1 | Write current mode's saved status |
| spsr_wr_data | input | DW | Saved-status write data |
| spsr_rd_data | output | DW | Current mode's saved status |
| exc_en | input | 1 | Exception-entry strobe |
| exc_mode | input | 5 | Mode being entered |
| exc_lr | input | DW | Return address for the target link register |
| exc_cpsr | input | DW | Status word to save for the target mode |

## Verification
A wrong bank mapping does not show when the write happens. It shows only when a later read of the same register number is made in a mode that should see a different copy, or the same copy. The random stimulus therefore switches mode almost every cycle, so such a read follows within a few cycles. A wrong exception priority or a lost saved-status write appears one cycle after the edge on the target mode's register-14 read or saved-status read. A forwarding error appears in the same cycle as the write, as a new value where the old one is required.

// File: rtl/bnk_pkg.sv
package bnk_pkg;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  localparam logic [4:0] MD_USR = 5'b10000;
  localparam logic [4:0] MD_FIQ = 5'b10001;
  localparam logic [4:0] MD_IRQ = 5'b10010;
  localparam logic [4:0] MD_SVC = 5'b10011;
  localparam logic [4:0] MD_ABT = 5'b10111;
  localparam logic [4:0] MD_UND = 5'b11011;
  localparam logic [4:0] MD_SYS = 5'b11111;

  localparam int NSHARED = 7;   // registers 0..6
  localparam int NHIGH   = 6;   // registers 7..12
  localparam int NBANK   = 6;   // user/system plus five exception banks
  localparam int NSPSR   = NBANK - 1;
  localparam int HI_USR_BASE = NSHARED;
  localparam int HI_FIQ_BASE = NSHARED + NHIGH;
  localparam int SPLR_BASE   = NSHARED + 2 * NHIGH;
  localparam int NPHYS       = SPLR_BASE + 2 * NBANK;
  localparam int PIDX_W      = $clog2(NPHYS + 1);
  localparam int SSEL_W      = $clog2(NSPSR);
  localparam logic [PIDX_W-1:0] PHYS_NONE = PIDX_W'(NPHYS);

  function automatic bank_e bank_of(input logic [4:0] m);
    case (m)
      MD_FIQ:  return BK_FIQ;
      MD_IRQ:  return BK_IRQ;
      MD_SVC:  return BK_SVC;
      MD_ABT:  return BK_ABT;
      MD_UND:  return BK_UND;
      default: return BK_USR;
    endcase
  endfunction

  // Physical slot for a register number in a bank; PHYS_NONE for register 15.
  function automatic logic [PIDX_W-1:0] phys_of(input logic [3:0] r, input bank_e b);
    int v;
    if (r == 4'd15)                v = NPHYS;
    else if (int'(r) < NSHARED)    v = int'(r);
    else if (r <= 4'd12)           v = ((b == BK_FIQ) ? HI_FIQ_BASE : HI_USR_BASE) + int'(r) - NSHARED;
    else                           v = SPLR_BASE + 2 * int'(b) + int'(r) - 13;
    return PIDX_W'(v);
  endfunction

  function automatic logic [SSEL_W-1:0] spsr_slot(input bank_e b);
    return SSEL_W'(int'(b) - 1);
  endfunction

endpackage

// File: rtl/bnk_mode_decode.sv
module bnk_mode_decode
  import bnk_pkg::*;
(
  input  logic [4:0] mode,
  output bank_e      bank,
  output logic       has_spsr
);
  always_comb begin
    bank     = bank_of(mode);
    has_spsr = (bank != BK_USR);
  end
endmodule

// File: rtl/bnk_gpr_array.sv
module bnk_gpr_array
  import bnk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPHYS-1:0]  we_n,
  input  logic [DW-1:0]     wd_n,
  input  logic [NPHYS-1:0]  we_x,
  input  logic [DW-1:0]     wd_x,
  input  logic [PIDX_W-1:0] ra,
  input  logic [PIDX_W-1:0] rb,
  output logic [DW-1:0]     qa,
  output logic [DW-1:0]     qb
);
  logic [NPHYS*DW-1:0] flat;

  for (genvar i = 0; i < NPHYS; i++) begin : g_ent
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (we_x[i]) q <= wd_x;
      else if (we_n[i]) q <= wd_n;
    end
    assign flat[i*DW +: DW] = q;
  end

  always_comb begin
    qa = '0;
    qb = '0;
    if (int'(ra) < NPHYS) qa = flat[int'(ra)*DW +: DW];
    if (int'(rb) < NPHYS) qb = flat[int'(rb)*DW +: DW];
  end
endmodule

// File: rtl/bnk_spsr_store.sv
module bnk_spsr_store
  import bnk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSPSR-1:0]  we_n,
  input  logic [DW-1:0]     wd_n,
  input  logic [NSPSR-1:0]  we_x,
  input  logic [DW-1:0]     wd_x,
  input  logic [SSEL_W-1:0] rsel,
  input  logic              rvalid,
  output logic [DW-1:0]     q
);
  logic [NSPSR*DW-1:0] flat;

  for (genvar i = 0; i < NSPSR; i++) begin : g_slot
    logic [DW-1:0] s;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       s <= '0;
      else if (we_x[i]) s <= wd_x;
      else if (we_n[i]) s <= wd_n;
    end
    assign flat[i*DW +: DW] = s;
  end

  always_comb begin
    q = '0;
    if (rvalid && int'(rsel) < NSPSR) q = flat[int'(rsel)*DW +: DW];
  end
endmodule

// File: rtl/bnk_regfile.sv
module bnk_regfile
  import bnk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    mode_i,
  input  logic [3:0]    rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [3:0]    rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] pc_i,
  output logic          pc_load_o,
  output logic [DW-1:0] pc_load_data,
  input  logic          spsr_wr_en,
  input  logic [DW-1:0] spsr_wr_data,
  output logic [DW-1:0] spsr_rd_data,
  input  logic          exc_en,
  input  logic [4:0]    exc_mode,
  input  logic [DW-1:0] exc_lr,
  input  logic [DW-1:0] exc_cpsr
);
  bank_e cur_bank, exc_bank;
  logic  cur_has, exc_has;

  bnk_mode_decode u_dec_cur (.mode(mode_i),   .bank(cur_bank), .has_spsr(cur_has));
  bnk_mode_decode u_dec_exc (.mode(exc_mode), .bank(exc_bank), .has_spsr(exc_has));

  logic [PIDX_W-1:0] pa, pb, pw, px;
  logic [NPHYS-1:0]  we_norm, we_exc;
  logic [NSPSR-1:0]  sp_we_norm, sp_we_exc;
  logic              wr_collide;
  logic [DW-1:0]     qa, qb;

  always_comb begin
    pa = phys_of(rd_a_idx, cur_bank);
    pb = phys_of(rd_b_idx, cur_bank);
    pw = phys_of(wr_idx,   cur_bank);
    px = phys_of(4'd14,    exc_bank);

    we_norm = '0;
    if (wr_en && pw != PHYS_NONE) we_norm[pw] = 1'b1;
    we_exc = '0;
    if (exc_en && exc_has) we_exc[px] = 1'b1;

    sp_we_norm = '0;
    if (spsr_wr_en && cur_has) sp_we_norm[spsr_slot(cur_bank)] = 1'b1;
    sp_we_exc = '0;
    if (exc_en && exc_has) sp_we_exc[spsr_slot(exc_bank)] = 1'b1;
  end

  // Named event for the checker: both ports aimed at one storage cell.
  assign wr_collide = |(we_norm & we_exc);

  bnk_gpr_array #(.DW(DW)) u_gpr (
    .clk(clk), .rst_n(rst_n),
    .we_n(we_norm), .wd_n(wr_data),
    .we_x(we_exc),  .wd_x(exc_lr),
    .ra(pa), .rb(pb), .qa(qa), .qb(qb)
  );

  bnk_spsr_store #(.DW(DW)) u_spsr (
    .clk(clk), .rst_n(rst_n),
    .we_n(sp_we_norm), .wd_n(spsr_wr_data),
    .we_x(sp_we_exc),  .wd_x(exc_cpsr),
    .rsel(spsr_slot(cur_bank)), .rvalid(cur_has),
    .q(spsr_rd_data)
  );

  always_comb begin
    rd_a_data    = (rd_a_idx == 4'd15) ? pc_i : qa;
    rd_b_data    = (rd_b_idx == 4'd15) ? pc_i : qb;
    pc_load_o    = wr_en && (wr_idx == 4'd15);
    pc_load_data = wr_data;
  end
endmodule

// File: rtl/bnk_regfile_chk.sv
module bnk_regfile_chk
  import bnk_pkg::*;
#(
  parameter int DW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [4:0]       mode_i,
  input logic [3:0]       rd_a_idx,
  input logic [DW-1:0]    rd_a_data,
  input logic [3:0]       rd_b_idx,
  input logic [DW-1:0]    rd_b_data,
  input logic             wr_en,
  input logic [3:0]       wr_idx,
  input logic [DW-1:0]    wr_data,
  input logic             exc_en,
  input logic [4:0]       exc_mode,
  input logic [DW-1:0]    exc_lr,
  input logic [DW-1:0]    exc_cpsr,
  input logic [DW-1:0]    spsr_rd_data,
  input logic [NPHYS-1:0] we_norm,
  input logic [NPHYS-1:0] we_exc,
  input logic             exc_has,
  input logic             wr_collide
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R7: a stored write is seen next cycle in the same mode
  a_r7_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(wr_en) && $past(wr_idx) != 4'd15 && !$past(wr_collide)
     && rd_a_idx == $past(wr_idx) && mode_i == $past(mode_i))
    |-> rd_a_data == $past(wr_data));

  // R8: exception entry sets the target link register
  a_r8_exc_lr: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(exc_en) && $past(exc_has) && mode_i == $past(exc_mode) && rd_b_idx == 4'd14)
    |-> rd_b_data == $past(exc_lr));

  // R8: exception entry sets the target saved status
  a_r8_exc_spsr: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(exc_en) && $past(exc_has) && mode_i == $past(exc_mode))
    |-> spsr_rd_data == $past(exc_cpsr));

  // R11: the two read ports agree on the same register number
  a_r11_ports_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == rd_b_idx) |-> rd_a_data == rd_b_data);

  // R9: each write source hits at most one cell
  a_r9_onehot_enables: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_norm) && $onehot0(we_exc));
endmodule

bind bnk_regfile bnk_regfile_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_bnk_regfile.sv
`timescale 1ns/1ps
module sim_bnk_regfile;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    mode_i = 5'b10000;
  logic [3:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0, pc_i = '0, pc_load_data;
  logic          wr_en = 1'b0, pc_load_o, spsr_wr_en = 1'b0, exc_en = 1'b0;
  logic [DW-1:0] spsr_wr_data = '0, spsr_rd_data, exc_lr = '0, exc_cpsr = '0;
  logic [4:0]    exc_mode = 5'b10000;

  bnk_regfile #(.DW(DW)) u0 (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // model: one copy per (bank, register); writes fan out to every alias
  logic [DW-1:0] mdl [6][15];
  logic [DW-1:0] msp [6];

  function automatic int bk(input logic [4:0] m);
    if (m == 5'b10001) return 1;
    if (m == 5'b10010) return 2;
    if (m == 5'b10011) return 3;
    if (m == 5'b10111) return 4;
    if (m == 5'b11011) return 5;
    return 0;
  endfunction

  function automatic bit alias_of(input int b1, input int b2, input int r);
    if (r <= 6)  return 1'b1;
    if (r <= 12) return (b1 == 1) == (b2 == 1);
    return b1 == b2;
  endfunction

  function automatic string area(input int r, input int b);
    if (r == 15) return "R6";
    if (r >= 13) return "R5";
    if (r >= 7 && b == 1) return "R4";
    return "R3";
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [4:0] md, input logic [3:0] ra, input logic [3:0] rb,
                      input bit we, input logic [3:0] wi, input logic [DW-1:0] wd,
                      input logic [DW-1:0] pc, input bit se, input logic [DW-1:0] sd,
                      input bit xe, input logic [4:0] xm, input logic [DW-1:0] xl, input logic [DW-1:0] xc);
    int b, xb;
    logic [DW-1:0] ea, eb;
    @(negedge clk);
    mode_i = md; rd_a_idx = ra; rd_b_idx = rb; wr_en = we; wr_idx = wi; wr_data = wd;
    pc_i = pc; spsr_wr_en = se; spsr_wr_data = sd; exc_en = xe; exc_mode = xm;
    exc_lr = xl; exc_cpsr = xc;
    #1;
    b  = bk(md);
    xb = bk(xm);
    ea = (ra == 4'd15) ? pc : mdl[b][ra];
    eb = (rb == 4'd15) ? pc : mdl[b][rb];
    chk((tag != "") ? tag : area(int'(ra), b), rd_a_data, ea);
    chk((tag != "") ? tag : area(int'(rb), b), rd_b_data, eb);
    chk((tag != "") ? tag : "R10", spsr_rd_data, (b == 0) ? '0 : msp[b]);
    chk((tag != "") ? tag : "R6", {31'd0, pc_load_o}, {31'd0, we && wi == 4'd15});
    if (we && wi == 4'd15) chk("R6", pc_load_data, wd);
    @(posedge clk);
    if (we && wi != 4'd15)
      for (int k = 0; k < 6; k++) if (alias_of(b, k, int'(wi))) mdl[k][wi] = wd;
    if (se && b != 0) msp[b] = sd;
    if (xe && xb != 0) begin
      mdl[xb][14] = xl;
      msp[xb]     = xc;
    end
  endtask

  task automatic rd(input string tag, input logic [4:0] md, input logic [3:0] ra, input logic [3:0] rb);
    step(tag, md, ra, rb, 0, 4'd0, '0, 32'hC0DE_0000, 0, '0, 0, 5'b10000, '0, '0);
  endtask

  task automatic wr(input logic [4:0] md, input logic [3:0] wi, input logic [DW-1:0] wd);
    step("R7", md, wi, 4'd0, 1, wi, wd, 32'h0, 0, '0, 0, 5'b10000, '0, '0);
  endtask

  localparam logic [4:0] MODES [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111};

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 6; k++) begin
      msp[k] = '0;
      for (int r = 0; r < 15; r++) mdl[k][r] = '0;
    end
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: reset contents in every mode
    for (int m = 0; m < 7; m++)
      for (int r = 0; r < 15; r += 2) rd("R1", MODES[m], 4'(r), 4'(r + 1));

    // R6: register 15 read and write
    rd("R6", 5'b10011, 4'd15, 4'd15);
    step("R6", 5'b10000, 4'd0, 4'd15, 1, 4'd15, 32'hFEED_F00D, 32'h0000_1234, 0, '0, 0, 5'b10000, '0, '0);
    rd("R6", 5'b10000, 4'd14, 4'd13);

    // R7: old value in write cycle, new value next cycle
    wr(5'b10000, 4'd3, 32'hAAAA_0003);
    rd("R7", 5'b10000, 4'd3, 4'd3);
    wr(5'b10010, 4'd3, 32'hBBBB_0003);
    rd("R3", 5'b11011, 4'd3, 4'd9);

    // R4 / R3: fast-interrupt high registers
    wr(5'b10001, 4'd9, 32'h0F19_0009);
    wr(5'b10011, 4'd9, 32'h5C00_0009);
    rd("R4", 5'b10001, 4'd9, 4'd10);
    rd("R3", 5'b10000, 4'd9, 4'd12);

    // R5 / R2: user and system share; invalid mode acts as user
    wr(5'b11111, 4'd13, 32'h5157_000D);
    rd("R5", 5'b10000, 4'd13, 4'd14);
    wr(5'b00101, 4'd14, 32'h1BAD_000E);
    rd("R2", 5'b11111, 4'd14, 4'd13);
    rd("R5", 5'b10111, 4'd13, 4'd14);

    // R8: exception entry into supervisor, then into user (ignored)
    step("R8", 5'b10000, 4'd0, 4'd1, 0, 4'd0, '0, '0, 0, '0, 1, 5'b10011, 32'h0000_8004, 32'h6000_00D3);
    rd("R8", 5'b10011, 4'd14, 4'd13);
    step("R8", 5'b10000, 4'd0, 4'd1, 0, 4'd0, '0, '0, 0, '0, 1, 5'b11111, 32'hDEAD_0001, 32'hDEAD_0002);
    rd("R8", 5'b10000, 4'd14, 4'd13);
    rd("R8", 5'b11111, 4'd14, 4'd0);

    // R9: collisions on link register and saved status; other write still lands
    step("R9", 5'b10010, 4'd0, 4'd0, 1, 4'd14, 32'h1111_1111, '0, 1, 32'h2222_2222, 1, 5'b10010, 32'h3333_3333, 32'h4444_4444);
    rd("R9", 5'b10010, 4'd14, 4'd14);
    step("R9", 5'b10111, 4'd0, 4'd0, 1, 4'd5, 32'h5555_0005, '0, 0, '0, 1, 5'b10001, 32'h6666_6666, 32'h7777_7777);
    rd("R9", 5'b10001, 4'd5, 4'd14);

    // R10: saved status in user ignored, in abort stored
    step("R10", 5'b10000, 4'd0, 4'd0, 0, 4'd0, '0, '0, 1, 32'h9999_9999, 0, 5'b10000, '0, '0);
    rd("R10", 5'b10000, 4'd0, 4'd0);
    step("R10", 5'b10111, 4'd0, 4'd0, 0, 4'd0, '0, '0, 1, 32'hABAB_0017, 0, 5'b10000, '0, '0);
    rd("R10", 5'b10111, 4'd1, 4'd2);

    // R11: independent ports
    rd("R11", 5'b10001, 4'd9, 4'd3);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] md, xm;
      md = (($urandom % 8) == 0) ? 5'($urandom) : MODES[$urandom % 7];
      xm = MODES[$urandom % 7];
      step("", md, 4'($urandom), 4'($urandom), ($urandom % 3) != 0, 4'($urandom), $urandom,
           $urandom, ($urandom % 4) == 0, $urandom, ($urandom % 6) == 0, xm, $urandom, $urandom);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule